// File: doc/BRIEF.md
# I2C Controller System Test Logic

This block is the test-control corner of a multimaster I2C controller. A 16-bit control word, written through a simple register port, picks one of four behaviours. In functional mode the block leaves the bus alone. In clock-test mode it drives SCL with a free-running clock whose period comes from the controller's prescaler and SCL low/high counts. In loopback mode, bytes written to the data port go through an 8-entry transmit FIFO and an 8-entry receive FIFO and can then be read back from the data port, while software drives the SCL and SDA pads directly from the control word.

A status-force bit sets all six raw interrupt flags at once. The flags are sticky: releasing the force bit leaves them set, and software clears each flag by writing a one to its position. Both pads are open-drain: an asserted enable pulls the line low, and a released pad lets the line float high.

Top module: `i2c_systest_ctl`

## Requirements
- R1: After reset the enable, mode and force fields read 0, both pad-output bits read 1, no pad is pulled, every raw flag is 0 and the read data is 0x00.
- R2: The control word is laid out as bit 15 enable, bits [13:12] mode, bit 11 status force, bit 3 SCL drive value, bit 2 SCL line level, bit 1 SDA drive value and bit 0 SDA line level; all other bits read 0.
- R3: When enable is 0, or when the mode is 00 (functional) or 01 (reserved), both pad enables are low.
- R4: A write changes bits 3 and 1 only if enable was already 1 before that write; bits 2 and 0 always show the live SCL and SDA line levels.
- R5: With enable 1 and mode 10, SCL is pulled low for (low count + 7) x (prescaler + 1) cycles, then released for (high count + 5) x (prescaler + 1) cycles, repeating. The first low phase starts right after the entering write, and SCL is released as soon as the mode is left.
- R6: With enable 1, mode 11 and operating mode 00 or 01, the SCL pad is pulled exactly when bit 3 is 0, and the SDA pad exactly when bit 1 is 0.
- R7: With operating mode 10 or 11 there is no loopback: the pads are released, and data writes and reads leave both FIFOs unchanged.
- R8: In loopback, bytes come out of the data port in the order they were written. At most one byte moves from the transmit FIFO to the receive FIFO per cycle, and only while the receive FIFO is not full. Each move sets raw flag bit 0 (transmit ready) and bit 1 (receive ready).
- R9: A data write while the 8-entry transmit FIFO is full is discarded and sets raw flag bit 2 (transmit underflow).
- R10: A data read while the receive FIFO is empty leaves the read data at its last value.
- R11: While enable and force are both 1, all six raw flags (bit 0 transmit ready, 1 receive ready, 2 transmit underflow, 3 receive overrun, 4 access ready, 5 no acknowledge) are 1 from the next cycle on.
- R12: A raw flag clears only when a one is written to its position on the clear port, and a set in the same cycle wins; clearing the force bit clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 16 | Control word write data |
| test_reg_q | output | 16 | Control word read value |
| opmode | input | 2 | Operating mode of the controller (00 fast/standard, 01 high speed) |
| presc | input | 8 | Prescaler value |
| scl_low_cnt | input | 8 | SCL low-phase count |
| scl_high_cnt | input | 8 | SCL high-phase count |
| data_wr | input | 1 | Data port write strobe |
| data_wdata | input | 8 | Data port write byte |
| data_rd | input | 1 | Data port read strobe |
| data_rdata | output | 8 | Last byte read from the receive FIFO |
| sts_w1c | input | 6 | Write-one-to-clear mask for the raw flags |
| raw_sts | output | 6 | Raw interrupt flags |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
A corrupted control field shows at the read port in the cycle after the write, and it also changes which pads are pulled in that same cycle. A wrong FIFO pointer or count shows as a wrong, repeated or missing byte on the first read after the fault, or as a transmit-underflow flag that is missing or raised early. A phase counter that is off by one shifts the next SCL edge by one prescaled period, so the first affected edge in clock-test mode gives it away. A flag that clears on its own, or is not set by force, shows on the raw-flag port one cycle later.

// File: rtl/i2c_systest_pkg.sv
package i2c_systest_pkg;
   localparam int REG_W      = 16;
   localparam int EN_BIT     = 15;
   localparam int MODE_HI    = 13;
   localparam int MODE_LO    = 12;
   localparam int FORCE_BIT  = 11;
   localparam int SCLO_BIT   = 3;
   localparam int SCLI_BIT   = 2;
   localparam int SDAO_BIT   = 1;
   localparam int SDAI_BIT   = 0;
   localparam int NUM_FLAGS  = 6;
   localparam int FL_TXRDY   = 0;
   localparam int FL_RXRDY   = 1;
   localparam int FL_TXUDF   = 2;

   typedef enum logic [1:0] {
      TM_FUNC   = 2'b00,
      TM_RSVD   = 2'b01,
      TM_SCLCLK = 2'b10,
      TM_LOOP   = 2'b11
   } test_mode_e;
endpackage

// File: rtl/i2c_st_fifo.sv
module i2c_st_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic [W-1:0]               din,
   input  logic                       pop,
   output logic [W-1:0]               dout,
   output logic                       empty,
   output logic                       full,
   output logic [$clog2(DEPTH+1)-1:0] count
);
   localparam int  AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int  CW   = $clog2(DEPTH+1);
   localparam bit  POW2 = (DEPTH & (DEPTH - 1)) == 0;

   if (DEPTH < 2) begin : g_bad_depth
      $error("i2c_st_fifo: DEPTH must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("i2c_st_fifo: W must be at least 1");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_p, rd_p, wr_nx, rd_nx;
   logic          do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rd_p];

   if (POW2) begin : g_wrap_pow2
      assign wr_nx = wr_p + 1'b1;
      assign rd_nx = rd_p + 1'b1;
   end else begin : g_wrap_cmp
      assign wr_nx = (wr_p == AW'(DEPTH - 1)) ? '0 : wr_p + 1'b1;
      assign rd_nx = (rd_p == AW'(DEPTH - 1)) ? '0 : rd_p + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_p] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_p  <= '0;
         rd_p  <= '0;
         count <= '0;
      end else begin
         if (do_push) wr_p <= wr_nx;
         if (do_pop)  rd_p <= rd_nx;
         if (do_push && !do_pop)      count <= count + 1'b1;
         else if (do_pop && !do_push) count <= count - 1'b1;
      end
   end

   AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH)); // R9
   AST_FIFO_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> (count == CW'(DEPTH))); // R9
endmodule

// File: rtl/i2c_st_sclgen.sv
module i2c_st_sclgen #(
   parameter int PSC_W    = 8,
   parameter int CNT_W    = 8,
   parameter int LOW_ADD  = 7,
   parameter int HIGH_ADD = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic [PSC_W-1:0] psc,
   input  logic [CNT_W-1:0] low_cnt,
   input  logic [CNT_W-1:0] high_cnt,
   output logic             scl_low
);
   localparam int PH_W = CNT_W + 1;

   if (LOW_ADD < 1 || HIGH_ADD < 1) begin : g_bad_add
      $error("i2c_st_sclgen: phase offsets must be positive");
   end
   if ((1 << CNT_W) + LOW_ADD > (1 << PH_W) || (1 << CNT_W) + HIGH_ADD > (1 << PH_W)) begin : g_bad_span
      $error("i2c_st_sclgen: phase offsets overflow the phase counter");
   end

   logic [PSC_W-1:0] pre_q;
   logic [PH_W-1:0]  ph_q;
   logic [PH_W-1:0]  limit;
   logic             low_q;
   logic             tick;

   assign tick    = (pre_q == psc);
   assign limit   = low_q ? ({1'b0, low_cnt}  + PH_W'(LOW_ADD))
                          : ({1'b0, high_cnt} + PH_W'(HIGH_ADD));
   assign scl_low = active && low_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
         ph_q  <= '0;
         low_q <= 1'b1;
      end else if (!active) begin
         pre_q <= '0;
         ph_q  <= '0;
         low_q <= 1'b1;
      end else if (tick) begin
         pre_q <= '0;
         if (ph_q == limit - PH_W'(1)) begin
            ph_q  <= '0;
            low_q <= !low_q;
         end else begin
            ph_q <= ph_q + 1'b1;
         end
      end else begin
         pre_q <= pre_q + 1'b1;
      end
   end

   AST_CLK_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> scl_low); // R5
   AST_CLK_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (ph_q < limit)); // R5
endmodule

// File: rtl/i2c_systest_ctl.sv
module i2c_systest_ctl
   import i2c_systest_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int FIFO_DEPTH = 8,
   parameter int PSC_W      = 8,
   parameter int CNT_W      = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_wr,
   input  logic [REG_W-1:0]     reg_wdata,
   output logic [REG_W-1:0]     test_reg_q,
   input  logic [1:0]           opmode,
   input  logic [PSC_W-1:0]     presc,
   input  logic [CNT_W-1:0]     scl_low_cnt,
   input  logic [CNT_W-1:0]     scl_high_cnt,
   input  logic                 data_wr,
   input  logic [DATA_W-1:0]    data_wdata,
   input  logic                 data_rd,
   output logic [DATA_W-1:0]    data_rdata,
   input  logic [NUM_FLAGS-1:0] sts_w1c,
   output logic [NUM_FLAGS-1:0] raw_sts,
   input  logic                 scl_in,
   input  logic                 sda_in,
   output logic                 scl_oe,
   output logic                 sda_oe
);
   localparam int CW = $clog2(FIFO_DEPTH + 1);

   if (FIFO_DEPTH < 2) begin : g_bad_depth
      $error("i2c_systest_ctl: FIFO_DEPTH must be at least 2");
   end

   logic       en_q, force_q, sclo_q, sdao_q;
   test_mode_e mode_q;
   logic       clk_on, op_ok, lpbk, move, ovf;
   logic       scl_low;
   logic       tx_empty, tx_full, rx_empty, rx_full;
   logic [DATA_W-1:0]    tx_dout, rx_dout;
   logic [CW-1:0]        tx_cnt, rx_cnt;
   logic [NUM_FLAGS-1:0] set_vec;
   logic                 unused_wbits;

   assign unused_wbits = ^{reg_wdata[14], reg_wdata[10:4], reg_wdata[SCLI_BIT], reg_wdata[SDAI_BIT]};

   // control word
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         mode_q  <= TM_FUNC;
         force_q <= 1'b0;
         sclo_q  <= 1'b1;
         sdao_q  <= 1'b1;
      end else if (reg_wr) begin
         en_q    <= reg_wdata[EN_BIT];
         mode_q  <= test_mode_e'(reg_wdata[MODE_HI:MODE_LO]);
         force_q <= reg_wdata[FORCE_BIT];
         if (en_q) begin
            sclo_q <= reg_wdata[SCLO_BIT];
            sdao_q <= reg_wdata[SDAO_BIT];
         end
      end
   end

   always_comb begin
      test_reg_q                   = '0;
      test_reg_q[EN_BIT]           = en_q;
      test_reg_q[MODE_HI:MODE_LO]  = mode_q;
      test_reg_q[FORCE_BIT]        = force_q;
      test_reg_q[SCLO_BIT]         = sclo_q;
      test_reg_q[SCLI_BIT]         = scl_in;
      test_reg_q[SDAO_BIT]         = sdao_q;
      test_reg_q[SDAI_BIT]         = sda_in;
   end

   // mode decode
   assign clk_on = en_q && (mode_q == TM_SCLCLK);
   assign op_ok  = (opmode == 2'b00) || (opmode == 2'b01);
   assign lpbk   = en_q && (mode_q == TM_LOOP) && op_ok;

   // clock test generator
   i2c_st_sclgen #(
      .PSC_W (PSC_W),
      .CNT_W (CNT_W)
   ) u_sclgen (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (clk_on),
      .psc      (presc),
      .low_cnt  (scl_low_cnt),
      .high_cnt (scl_high_cnt),
      .scl_low  (scl_low)
   );

   // loopback path
   assign move = lpbk && !tx_empty && !rx_full;
   assign ovf  = lpbk && data_wr && tx_full;

   i2c_st_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (lpbk && data_wr),
      .din   (data_wdata),
      .pop   (move),
      .dout  (tx_dout),
      .empty (tx_empty),
      .full  (tx_full),
      .count (tx_cnt)
   );

   i2c_st_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (move),
      .din   (tx_dout),
      .pop   (lpbk && data_rd),
      .dout  (rx_dout),
      .empty (rx_empty),
      .full  (rx_full),
      .count (rx_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           data_rdata <= '0;
      else if (lpbk && data_rd && !rx_empty) data_rdata <= rx_dout;
   end

   // raw flags
   always_comb begin
      set_vec = '0;
      if (en_q && force_q) set_vec = '1;
      if (move) begin
         set_vec[FL_TXRDY] = 1'b1;
         set_vec[FL_RXRDY] = 1'b1;
      end
      if (ovf) set_vec[FL_TXUDF] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) raw_sts <= '0;
      else        raw_sts <= (raw_sts & ~sts_w1c) | set_vec;
   end

   // pads
   assign scl_oe = clk_on ? scl_low : (lpbk && !sclo_q);
   assign sda_oe = lpbk && !sdao_q;

   AST_PAD_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> (!scl_oe && !sda_oe)); // R3
   AST_PAD_BITS_RO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !en_q) |=> (sclo_q == $past(sclo_q) && sdao_q == $past(sdao_q))); // R4
   AST_NO_LPBK_OPMODE: assert property (@(posedge clk) disable iff (!rst_n)
      opmode[1] |=> (tx_cnt == $past(tx_cnt) && rx_cnt == $past(rx_cnt))); // R7
   AST_FORCE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && force_q) |=> (&raw_sts)); // R11
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((raw_sts & $past(raw_sts & ~sts_w1c)) == $past(raw_sts & ~sts_w1c))); // R12
endmodule

// File: tb/test_i2c_systest_ctl.sv
module test_i2c_systest_ctl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] test_reg_q;
   logic [1:0]  opmode = 2'b00;
   logic [7:0]  presc = 8'd1;
   logic [7:0]  scl_low_cnt = 8'd2;
   logic [7:0]  scl_high_cnt = 8'd1;
   logic        data_wr = 1'b0;
   logic [7:0]  data_wdata = '0;
   logic        data_rd = 1'b0;
   logic [7:0]  data_rdata;
   logic [5:0]  sts_w1c = '0;
   logic [5:0]  raw_sts;
   logic        scl_in, sda_in, scl_oe, sda_oe;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #4 clk = !clk;   // 125 MHz

   assign scl_in = !scl_oe;   // open-drain lines with pull-ups
   assign sda_in = !sda_oe;

   i2c_systest_ctl i_i2c_systest_ctl (
      .clk, .rst_n, .reg_wr, .reg_wdata, .test_reg_q, .opmode, .presc,
      .scl_low_cnt, .scl_high_cnt, .data_wr, .data_wdata, .data_rd,
      .data_rdata, .sts_w1c, .raw_sts, .scl_in, .sda_in, .scl_oe, .sda_oe
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h @%0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- reference model ----------------
   bit         m_en, m_force, m_sclo, m_sdao;
   logic [1:0] m_mode;
   logic [5:0] m_raw, nraw;
   logic [7:0] m_rd;
   logic [7:0] m_tx[$];
   logic [7:0] m_rx[$];
   int         m_k, tx_n, rx_n;
   bit         lp, mv, old_ct, new_ct;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_en = 0; m_force = 0; m_sclo = 1; m_sdao = 1; m_mode = 2'b00;
         m_raw = '0; m_rd = '0; m_tx.delete(); m_rx.delete(); m_k = 0;
      end else begin
         lp   = m_en && m_mode == 2'b11 && opmode < 2'd2;
         nraw = m_raw & ~sts_w1c;
         if (m_en && m_force) nraw = '1;
         tx_n = m_tx.size();
         rx_n = m_rx.size();
         mv   = lp && tx_n > 0 && rx_n < 8;
         if (lp && data_rd && rx_n > 0) m_rd = m_rx.pop_front();
         if (mv) begin
            m_rx.push_back(m_tx.pop_front());
            nraw[1:0] = 2'b11;
         end
         if (lp && data_wr) begin
            if (tx_n < 8) m_tx.push_back(data_wdata);
            else          nraw[2] = 1'b1;
         end
         m_raw  = nraw;
         old_ct = m_en && m_mode == 2'b10;
         if (reg_wr) begin
            if (m_en) begin
               m_sclo = reg_wdata[3];
               m_sdao = reg_wdata[1];
            end
            m_en    = reg_wdata[15];
            m_mode  = reg_wdata[13:12];
            m_force = reg_wdata[11];
         end
         new_ct = m_en && m_mode == 2'b10;
         if (new_ct) m_k = old_ct ? m_k + 1 : 0;
      end
   end

   // per-cycle comparison, half a period after the edge
   always @(negedge clk) begin
      if (rst_n) begin
         bit e_lp, e_ct, e_scl, e_sda;
         int lowlen, period;
         logic [15:0] e_reg;
         lowlen = (int'(scl_low_cnt) + 7) * (int'(presc) + 1);
         period = lowlen + (int'(scl_high_cnt) + 5) * (int'(presc) + 1);
         e_lp  = m_en && m_mode == 2'b11 && opmode < 2'd2;
         e_ct  = m_en && m_mode == 2'b10;
         e_scl = e_ct ? ((m_k % period) < lowlen) : (e_lp && !m_sclo);
         e_sda = e_lp && !m_sdao;
         e_reg = {m_en, 1'b0, m_mode, m_force, 7'b0, m_sclo, !e_scl, m_sdao, !e_sda};
         chk("R5,R6 scl_oe per cycle", scl_oe, e_scl);
         chk("R3,R6 sda_oe per cycle", sda_oe, e_sda);
         chk("R2,R4 control word per cycle", test_reg_q, e_reg);
         chk("R8,R9,R11,R12 raw flags per cycle", raw_sts, m_raw);
         chk("R8,R10 read data per cycle", data_rdata, m_rd);
      end
   end

   // ---------------- stimulus helpers (called at edge + 1 ns) ----------------
   task automatic step();
      @(posedge clk); #1;
   endtask
   task automatic wreg(input logic [15:0] v);
      reg_wr = 1'b1; reg_wdata = v; step(); reg_wr = 1'b0;
   endtask
   task automatic wbyte(input logic [7:0] b);
      data_wr = 1'b1; data_wdata = b; step(); data_wr = 1'b0;
   endtask
   task automatic rbyte();
      data_rd = 1'b1; step(); data_rd = 1'b0;
   endtask
   task automatic clr(input logic [5:0] m);
      sts_w1c = m; step(); sts_w1c = '0;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         fails++;
         $display("FAIL watchdog: run hung, actual=%0d cycles expected<20000", cyc);
         finish_run();
      end
   end

   initial begin
      int lows;
      repeat (3) step();
      rst_n = 1'b1;
      step();
      // R1 reset state
      chk("R1 control word after reset", test_reg_q, 16'h000F);
      chk("R1 raw flags after reset", raw_sts, 0);
      chk("R1 pads after reset", {scl_oe, sda_oe}, 0);
      chk("R1 read data after reset", data_rdata, 0);

      // R4 pad bits read-only while disabled
      wreg(16'h0000);
      chk("R4 drive bits kept while disabled", test_reg_q, 16'h000F);
      // R2 layout, R3 functional mode keeps pads free
      wreg(16'h8000);
      chk("R2 enable bit", test_reg_q, 16'h800F);
      wreg(16'h8000);
      chk("R4 drive bits written when enabled", test_reg_q, 16'h8005);
      chk("R3 functional mode releases pads", {scl_oe, sda_oe}, 0);
      wreg(16'h9000);
      chk("R3 reserved mode releases pads", {scl_oe, sda_oe}, 0);

      // R6 loopback pad control
      wreg(16'hB00A);
      chk("R6 pads released with drive bits 1", {scl_oe, sda_oe}, 0);
      wreg(16'hB002);
      chk("R6 SCL pulled by bit3=0", scl_oe, 1);
      chk("R6 SCL line seen in bit2", test_reg_q[2], 0);
      wreg(16'hB008);
      chk("R6 SDA pulled by bit1=0", {scl_oe, sda_oe}, 2'b01);
      wreg(16'hB00A);

      // R8 first-in first-out order
      for (int i = 0; i < 5; i++) wbyte(8'h11 + 8'(i));
      repeat (3) step();
      chk("R8 move sets ready flags", raw_sts & 6'h03, 6'h03);
      for (int i = 0; i < 5; i++) begin
         rbyte();
         chk("R8 loopback byte order", data_rdata, 8'h11 + i);
      end
      clr(6'h3F);
      chk("R12 write-one clears flags", raw_sts, 0);
      rbyte();
      chk("R10 empty read holds last byte", data_rdata, 8'h15);

      // R9 overflow
      for (int i = 0; i < 20; i++) wbyte(8'h40 + 8'(i));
      chk("R9 full write sets underflow flag", raw_sts[2], 1);
      for (int i = 0; i < 16; i++) begin
         rbyte();
         chk("R9 kept bytes in order", data_rdata, 8'h40 + i);
      end
      rbyte();
      chk("R10 drained read holds last byte", data_rdata, 8'h4F);
      clr(6'h3F);

      // R7 invalid operating mode
      wreg(16'hB002);
      opmode = 2'b10;
      step();
      chk("R7 pads released for opmode 10", {scl_oe, sda_oe}, 0);
      wbyte(8'h99);
      opmode = 2'b11;
      wbyte(8'h98);
      opmode = 2'b00;
      step();
      chk("R7 scl pad returns with opmode 00", scl_oe, 1);
      repeat (2) step();
      rbyte();
      chk("R7 no byte entered loopback", data_rdata, 8'h4F);
      chk("R7 no flags raised", raw_sts, 0);

      // R5 clock test: low 9*2=18 cycles, high 6*2=12 cycles
      wreg(16'hA000);
      chk("R5 first sample is low", scl_oe, 1);
      lows = 0;
      for (int i = 0; i < 60; i++) begin
         if (scl_oe) lows++;
         step();
      end
      chk("R5 low cycles in two periods", lows, 36);
      wreg(16'h8000);
      chk("R5 SCL released on exit", scl_oe, 0);

      // R11 / R12 forced flags
      wreg(16'h8800);
      step();
      chk("R11 force sets all flags", raw_sts, 6'h3F);
      wreg(16'h8000);
      repeat (3) step();
      chk("R12 release keeps flags", raw_sts, 6'h3F);
      clr(6'h05);
      chk("R12 selective clear", raw_sts, 6'h3A);
      wreg(16'h8800);
      sts_w1c = 6'h3F;
      repeat (3) step();
      chk("R12 set wins over clear", raw_sts, 6'h3F);
      sts_w1c = '0;
      wreg(16'h0000);
      clr(6'h3F);
      chk("R12 clear after disable", raw_sts, 0);
      chk("R3 disabled pads released", {scl_oe, sda_oe}, 0);

      repeat (4) step();
      finish_run();
   end
endmodule